// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns one parallel data word into an asynchronous serial frame on a single line. A control word sets the frame shape: 7 or 8 data bits, the bit order, the parity mode (none, a constant zero bit, even or odd), and one or two stop bits. The serial rate comes from a one-cycle enable tick that a separate divider supplies. The block counts no time of its own between ticks.

Data enters through a valid/ready handshake. A word and its frame settings are taken on a rising clock edge where `in_valid_i` and `in_ready_o` are both high. `in_ready_o` is high exactly when no frame is in progress. While it is low, the block applies back-pressure: a valid word offered at that time is not taken, and it has no effect on the frame on the line. The source must hold the word until a handshake completes if it wants the word sent. The frame settings are captured along with the data, so they may change freely between frames.

The line idles high. After a word is accepted, the next tick starts the low start bit. Each further tick moves the line to the next bit. The tick that ends the last stop bit clears `busy_o` and raises `tx_end_o` for one cycle.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset and between frames, `txd_o` is high, `busy_o` and `tx_end_o` are low, and `in_ready_o` is high.
- R2: A word is accepted only on a cycle with `in_valid_i` and `in_ready_o` both high, and `in_ready_o` is low while `busy_o` is high. A word offered while busy changes neither the frame in progress nor the line after it, and no later frame comes from it.
- R3: The line changes only in the cycle after a tick. The first tick after acceptance drives the start bit (low), and each later bit lasts exactly one tick interval.
- R4: `cfg_len8_i`=1 sends data bits 7..0. `cfg_len8_i`=0 sends only bits 6..0, and bit 7 has no effect on the frame.
- R5: `cfg_lsb_first_i`=1 sends bit 0 first. `cfg_lsb_first_i`=0 sends the highest sent bit first (bit 7 in 8-bit mode, bit 6 in 7-bit mode).
- R6: `cfg_parity_i`=2'b00 inserts no parity bit. `cfg_parity_i`=2'b01 inserts a parity bit that is always 0, whatever the data.
- R7: `cfg_parity_i`=2'b10 inserts a bit that makes the count of ones in the sent data plus parity even. 2'b11 makes that count odd. Only the data bits actually sent are counted.
- R8: `cfg_stop_i`=2'b10 ends the frame with two high stop bits. Every other code, including the prohibited 2'b11, gives one stop bit.
- R9: `tx_end_o` is high for exactly one cycle. That cycle follows the tick that ends the last stop bit, and `busy_o` goes low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle baud enable; one per bit time |
| in_valid_i | input | 1 | Data word offered |
| in_ready_o | output | 1 | Block can accept a word (no frame in progress) |
| in_data_i | input | 8 | Data word |
| cfg_len8_i | input | 1 | 1: eight data bits, 0: seven |
| cfg_lsb_first_i | input | 1 | 1: LSB first, 0: MSB first |
| cfg_parity_i | input | 2 | 00 none, 01 constant zero, 10 even, 11 odd |
| cfg_stop_i | input | 2 | 10 two stop bits, other codes one |
| txd_o | output | 1 | Serial line, idles high |
| busy_o | output | 1 | Frame in progress |
| tx_end_o | output | 1 | One-cycle pulse after the final stop bit |

## Verification
The assertions assume that `tick_i` is a known one-cycle pulse from reset onward and that the frame settings matter only in the accepting cycle. They treat any change of `txd_o` that is not preceded by a tick as an error. The bench raises a tick on every fourth cycle, holds `in_valid_i` for a single cycle per offer, and makes a fresh offer only while `in_ready_o` is high. The one exception is the overlap test, which offers a different word and different settings in the middle of a frame to exercise back-pressure.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_ZERO = 2'b01,
    PAR_EVEN = 2'b10,
    PAR_ODD  = 2'b11
  } par_mode_e;

  typedef enum logic [1:0] {
    STOP_NIL = 2'b00,
    STOP_ONE = 2'b01,
    STOP_TWO = 2'b10,
    STOP_BAD = 2'b11
  } stop_mode_e;

  typedef struct packed {
    logic       len_full;
    logic       lsb_first;
    par_mode_e  par;
    stop_mode_e stop;
  } frame_cfg_t;

endpackage

// File: rtl/uart_tx_framer.sv
// Combinational frame builder: lays out start, ordered data, parity and
// stop bits in transmit order (bit 0 leaves first) and gives the bit count.
module uart_tx_framer
  import uart_tx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = DATA_W + 4,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic [DATA_W-1:0]  data_i,
  input  frame_cfg_t         cfg_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic [CNT_W-1:0]   nbits_o
);

  logic [DATA_W-1:0] rev_full;
  logic [DATA_W-1:0] rev_short;
  logic [DATA_W-1:0] masked;
  logic [DATA_W-1:0] ordered;
  logic [CNT_W-1:0]  dlen;
  logic [CNT_W-1:0]  stops;
  logic              par_en;
  logic              par_bit;

  // Reversed views for MSB-first order, one for each data length.
  for (genvar g = 0; g < DATA_W; g++) begin : g_ord
    assign rev_full[g] = data_i[DATA_W-1-g];
    if (g < DATA_W - 1) begin : g_short
      assign rev_short[g] = data_i[DATA_W-2-g];
    end else begin : g_pad
      assign rev_short[g] = 1'b0;
    end
  end

  always_comb begin
    masked = data_i;
    if (!cfg_i.len_full) masked[DATA_W-1] = 1'b0;
    dlen = cfg_i.len_full ? CNT_W'(DATA_W) : CNT_W'(DATA_W - 1);
  end

  always_comb begin
    if (cfg_i.lsb_first)     ordered = masked;
    else if (cfg_i.len_full) ordered = rev_full;
    else                     ordered = rev_short;
  end

  // Parity covers only the bits that are sent.
  always_comb begin
    par_en = (cfg_i.par != PAR_NONE);
    unique case (cfg_i.par)
      PAR_EVEN: par_bit = ^masked;
      PAR_ODD:  par_bit = ~^masked;
      default:  par_bit = 1'b0;
    endcase
  end

  always_comb begin
    stops = (cfg_i.stop == STOP_TWO) ? CNT_W'(2) : CNT_W'(1);
  end

  always_comb begin
    frame_o    = '1;
    frame_o[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (CNT_W'(i) < dlen) frame_o[1+i] = ordered[i];
    end
    if (par_en) frame_o[1 + int'(dlen)] = par_bit;
    nbits_o = CNT_W'(1) + dlen + CNT_W'(par_en) + stops;
  end

endmodule

// File: rtl/uart_tx_serializer.sv
// Tick-paced shifter. A loaded frame waits for one arming tick so that the
// start bit lasts a full tick interval, then one bit per tick.
module uart_tx_serializer #(
  parameter int FRAME_W = 12,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [CNT_W-1:0]   nbits_i,
  output logic               busy_o,
  output logic               line_o,
  output logic               done_o
);

  logic               busy_q;
  logic               live_q;
  logic               done_q;
  logic [FRAME_W-1:0] shreg_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   nbits_q;
  logic               last_bit;

  assign last_bit = (cnt_q == nbits_q - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      live_q  <= 1'b0;
      done_q  <= 1'b0;
      shreg_q <= '1;
      cnt_q   <= '0;
      nbits_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (load_i && !busy_q) begin
        busy_q  <= 1'b1;
        live_q  <= 1'b0;
        shreg_q <= frame_i;
        cnt_q   <= '0;
        nbits_q <= nbits_i;
      end else if (busy_q && tick_i) begin
        if (!live_q) begin
          live_q <= 1'b1;
        end else if (last_bit) begin
          busy_q  <= 1'b0;
          live_q  <= 1'b0;
          done_q  <= 1'b1;
          shreg_q <= '1;
        end else begin
          shreg_q <= {1'b1, shreg_q[FRAME_W-1:1]};
          cnt_q   <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  assign line_o = live_q ? shreg_q[0] : 1'b1;
  assign busy_o = busy_q;
  assign done_o = done_q;

  assert_line_moves_on_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(line_o) |-> $past(tick_i));

  assert_start_bit_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(live_q) |-> !line_o);

  assert_end_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_end_with_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $fell(busy_o));

  assert_count_in_frame_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q < nbits_q));

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              cfg_len8_i,
  input  logic              cfg_lsb_first_i,
  input  logic [1:0]        cfg_parity_i,
  input  logic [1:0]        cfg_stop_i,
  output logic              txd_o,
  output logic              busy_o,
  output logic              tx_end_o
);

  localparam int FRAME_W = DATA_W + 4;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  frame_cfg_t         cfg;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   nbits;
  logic               accept;
  logic               busy;

  assign cfg.len_full  = cfg_len8_i;
  assign cfg.lsb_first = cfg_lsb_first_i;
  assign cfg.par       = par_mode_e'(cfg_parity_i);
  assign cfg.stop      = stop_mode_e'(cfg_stop_i);

  assign in_ready_o = !busy;
  assign accept     = in_valid_i && in_ready_o;

  uart_tx_framer #(
    .DATA_W (DATA_W),
    .FRAME_W(FRAME_W),
    .CNT_W  (CNT_W)
  ) u_framer (
    .data_i (in_data_i),
    .cfg_i  (cfg),
    .frame_o(frame),
    .nbits_o(nbits)
  );

  uart_tx_serializer #(
    .FRAME_W(FRAME_W),
    .CNT_W  (CNT_W)
  ) u_ser (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .load_i (accept),
    .frame_i(frame),
    .nbits_i(nbits),
    .busy_o (busy),
    .line_o (txd_o),
    .done_o (tx_end_o)
  );

  assign busy_o = busy;

  assert_accept_needs_ready_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(in_valid_i && in_ready_o));

  assert_idle_line_high_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> txd_o);

endmodule

// File: tb/uart_frame_tx_bench.sv
module uart_frame_tx_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic       cfg_len8 = 1'b1;
  logic       cfg_lsb = 1'b1;
  logic [1:0] cfg_par = 2'b00;
  logic [1:0] cfg_stop = 2'b01;
  logic       txd;
  logic       busy;
  logic       tx_end;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  uart_frame_tx u_uart_frame_tx (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .tick_i         (tick),
    .in_valid_i     (in_valid),
    .in_ready_o     (in_ready),
    .in_data_i      (in_data),
    .cfg_len8_i     (cfg_len8),
    .cfg_lsb_first_i(cfg_lsb),
    .cfg_parity_i   (cfg_par),
    .cfg_stop_i     (cfg_stop),
    .txd_o          (txd),
    .busy_o         (busy),
    .tx_end_o       (tx_end)
  );

  // Baud tick: one cycle high out of every four, driven at the falling edge.
  initial begin
    int div = 0;
    forever begin
      @(negedge clk);
      div  = (div + 1) % 4;
      tick = (div == 0);
    end
  end

  // Vector: {expected bit count[17:14], data[13:6], len8[5], lsb[4], par[3:2], stop[1:0]}
  localparam logic [17:0] VEC [0:9] = '{
    {4'd10, 8'hA5, 1'b1, 1'b1, 2'b00, 2'b01},
    {4'd10, 8'hA5, 1'b1, 1'b0, 2'b00, 2'b01},
    {4'd9,  8'hC5, 1'b0, 1'b1, 2'b00, 2'b01},
    {4'd9,  8'hC5, 1'b0, 1'b0, 2'b00, 2'b01},
    {4'd11, 8'hFF, 1'b1, 1'b1, 2'b01, 2'b01},
    {4'd11, 8'h07, 1'b1, 1'b1, 2'b10, 2'b01},
    {4'd12, 8'h07, 1'b1, 1'b1, 2'b11, 2'b10},
    {4'd11, 8'h81, 1'b0, 1'b1, 2'b10, 2'b10},
    {4'd11, 8'h3C, 1'b1, 1'b0, 2'b11, 2'b11},
    {4'd11, 8'h00, 1'b1, 1'b0, 2'b00, 2'b10}
  };

  function automatic string vec_tag(int idx);
    case (idx)
      0, 1:    return "R5";
      2, 3:    return "R4";
      4:       return "R6";
      5, 6, 7: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Independent model of the expected line bits, in order sent.
  task automatic model(input logic [7:0] d, input logic len8, input logic lsb,
                       input logic [1:0] par, input logic [1:0] stop,
                       output int n, output logic [15:0] bits);
    int dl = len8 ? 8 : 7;
    int ones = 0;
    bits = '1;
    n = 0;
    bits[n] = 1'b0; n++;
    for (int i = 0; i < dl; i++) begin
      bits[n] = lsb ? d[i] : d[dl-1-i];
      n++;
      ones += d[i];
    end
    if (par != 2'b00) begin
      if (par == 2'b01)      bits[n] = 1'b0;
      else if (par == 2'b10) bits[n] = ones[0];
      else                   bits[n] = ~ones[0];
      n++;
    end
    bits[n] = 1'b1; n++;
    if (stop == 2'b10) begin bits[n] = 1'b1; n++; end
  endtask

  task automatic run_frame(input logic [7:0] d, input logic len8, input logic lsb,
                           input logic [1:0] par, input logic [1:0] stop,
                           input int exp_n, input string tag, input bit inject);
    int          mn;
    logic [15:0] mbits;
    logic [15:0] got = '1;
    logic [15:0] mask;
    int          n = 0;
    int          hold_bad = 0;
    int          guard = 0;
    logic        prev = 1'b1;
    bit          seen_done = 0;
    logic        busy_at_done = 1'b1;
    bit          injected = 0;
    bit          drop = 0;
    logic        t;
    model(d, len8, lsb, par, stop, mn, mbits);
    check(mn == exp_n, tag, "model bit count", mn, exp_n);
    @(negedge clk);
    check(in_ready === 1'b1, "R2", "ready before offer", in_ready, 1);
    in_data = d; cfg_len8 = len8; cfg_lsb = lsb; cfg_par = par; cfg_stop = stop;
    in_valid = 1'b1;
    @(posedge clk);
    #1 in_valid = 1'b0;
    while (!seen_done && guard < 200) begin
      @(posedge clk);
      t = tick;
      #2;
      guard++;
      if (drop) begin
        in_valid = 1'b0;
        drop = 0;
      end
      if (t) begin
        if (tx_end) begin
          seen_done = 1;
          busy_at_done = busy;
        end else begin
          if (n < 16) got[n] = txd;
          n++;
          prev = txd;
        end
      end else begin
        if (txd !== prev) hold_bad++;
        if (tx_end) hold_bad++;
      end
      if (inject && !injected && n == 4 && !t) begin
        check(in_ready === 1'b0, "R2", "ready while busy", in_ready, 0);
        in_data = ~d; cfg_len8 = ~len8; cfg_lsb = ~lsb; cfg_par = ~par;
        in_valid = 1'b1;
        injected = 1;
        drop = 1;
      end
    end
    mask = (16'h1 << exp_n) - 16'h1;
    check(seen_done, "R9", "end pulse seen", seen_done, 1);
    check(n == exp_n, tag, "bits sent", n, exp_n);
    check((got & mask) == (mbits & mask), tag, "frame bits", got & mask, mbits & mask);
    check(hold_bad == 0, "R3", "line held between ticks", hold_bad, 0);
    check(busy_at_done === 1'b0, "R9", "busy low with end pulse", busy_at_done, 0);
    @(posedge clk);
    #2;
    check(tx_end === 1'b0, "R9", "end pulse one cycle", tx_end, 0);
    check(txd === 1'b1, "R1", "line idle after frame", txd, 1);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #2;
    check(txd === 1'b1, "R1", "reset line", txd, 1);
    check(busy === 1'b0, "R1", "reset busy", busy, 0);
    check(tx_end === 1'b0, "R1", "reset end", tx_end, 0);
    check(in_ready === 1'b1, "R1", "reset ready", in_ready, 1);

    for (int v = 0; v < 10; v++) begin
      run_frame(VEC[v][13:6], VEC[v][5], VEC[v][4], VEC[v][3:2], VEC[v][1:0],
                int'(VEC[v][17:14]), vec_tag(v), 1'b0);
    end

    // R4: bit 7 must not matter in 7-bit mode.
    run_frame(8'h45, 1'b0, 1'b1, 2'b10, 2'b01, 10, "R4", 1'b0);
    run_frame(8'hC5, 1'b0, 1'b1, 2'b10, 2'b01, 10, "R4", 1'b0);
    // R6: forced zero with all-zero data and MSB first.
    run_frame(8'h00, 1'b1, 1'b0, 2'b01, 2'b10, 12, "R6", 1'b0);
    // R8: the unused 00 code gives one stop bit.
    run_frame(8'h5A, 1'b1, 1'b1, 2'b00, 2'b00, 10, "R8", 1'b0);

    // R2: a word offered mid-frame is not taken.
    run_frame(8'h96, 1'b1, 1'b1, 2'b11, 2'b01, 11, "R2", 1'b1);
    repeat (20) begin
      @(posedge clk);
      #2;
      if (busy !== 1'b0 || txd !== 1'b1) begin
        check(1'b0, "R2", "no frame from ignored offer", {busy, txd}, 2'b01);
        break;
      end
    end
    check(busy === 1'b0, "R2", "idle after ignored offer", busy, 0);
    check(in_ready === 1'b1, "R2", "ready after frame", in_ready, 1);

    // Back-to-back frames.
    run_frame(8'h01, 1'b1, 1'b0, 2'b10, 2'b10, 12, "R3", 1'b0);
    run_frame(8'hFE, 1'b1, 1'b1, 2'b11, 2'b01, 11, "R7", 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule